// File: doc/BRIEF.md
# Prioritized UART Interrupt Identification Unit

This block gathers every interrupt condition of a single UART channel and reduces them to one readable status byte that names only the most urgent pending source. Event-type conditions are single-cycle pulses, and the block latches each one into its own flag. The two receive conditions are levels that the receive path drives directly. Each source has its own enable bit that masks it before priority resolution. The flag itself is kept while its source is masked, so it appears as soon as the enable returns.

Software reads the status byte and dispatches on bits 5:0, then services that source. Servicing means reading the line or modem status register, writing the transmit holding register, or reading the status byte again for sources that clear on an identification read. A lower source shows up on the next read. Two extra levels on bits 5:4 report flow-control events and are visible only when the enhanced-feature input is high. The Xoff indication holds until an Xon arrives. Bits 7:6 report whether the FIFOs are in use.

Top module: `uart_irq_ident`

## Requirements
- R1: While `rst_n` is low at a clock edge, all latched flags and the FIFO-mode bit are cleared. After that edge, `status` reads 0x01 and `irq` is 0.
- R2: Bits 5:0 carry the code of the highest enabled pending source only. From highest to lowest the codes are: line error 0x06, receive timeout 0x0C, receive ready 0x04, transmit empty 0x02, modem change 0x00, Xoff/special 0x10, flow change 0x20. Receive timeout and receive ready share a level, and timeout wins when both are present.
- R3: Bit 0 is 0 when any enabled source is pending and 1 otherwise. `irq` is always the inverse of bit 0.
- R4: Bits 7:6 read 11 starting one clock after `fifo_en` is sampled high, and 00 starting one clock after it is sampled low.
- R5: When `enh_en` is 0, the Xoff and flow-change sources never appear in bits 5:0. Their flags are still latched, and they are reported once `enh_en` is 1.
- R6: The Xoff flag stays set until an `ev_xon` pulse, and reading the status byte does not clear it.
- R7: The line-error flag clears on `rd_line` and the modem flag clears on `rd_modem`, effective at the next clock. A status read does not clear either one.
- R8: The transmit-empty flag clears on `wr_thr`, or on `rd_status` while transmit empty is the reported source. The flow-change flag clears on `rd_status` while it is the reported source. A status read does not clear a flag that is not being reported.
- R9: `src_en` bit 0 enables line error, bit 1 both receive sources, bit 2 transmit empty, bit 3 modem, bit 4 Xoff, and bit 5 flow change. A cleared bit hides its source, but the source's flag is kept.
- R10: An event pulse sets its flag at the next clock edge, so the source is visible from the following cycle. If a set and a clear of the same flag happen in the same cycle, the set wins. The receive levels act in the same cycle.
- R11: The byte presented during a read cycle reflects the state before that read. Clears caused by the read appear one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | FIFO mode selected |
| enh_en | input | 1 | Enhanced-feature enable for levels 5 and 6 |
| src_en | input | 6 | Per-source enable bits (see R9) |
| ev_line_err | input | 1 | Pulse: receive line error |
| rx_ready | input | 1 | Level: receive data ready |
| rx_timeout | input | 1 | Level: receive character timeout |
| ev_thr_empty | input | 1 | Pulse: transmit holding register became empty |
| ev_modem | input | 1 | Pulse: modem input change |
| ev_xoff | input | 1 | Pulse: Xoff or special character detected |
| ev_xon | input | 1 | Pulse: Xon character detected |
| ev_flow_chg | input | 1 | Pulse: CTS/RTS flow-control state changed |
| rd_status | input | 1 | CPU read of this status byte |
| rd_line | input | 1 | CPU read of the line status register |
| rd_modem | input | 1 | CPU read of the modem status register |
| wr_thr | input | 1 | CPU write of the transmit holding register |
| status | output | 8 | Interrupt identification byte |
| irq | output | 1 | Interrupt request, high when a source is pending |

## Verification
A flag that is stuck or cleared at the wrong time shows up in bits 5:0 in the very next cycle in which it is the top pending source. This is why the stimulus stacks several sources and then peels them off one service access at a time. A wrong clear condition, such as a status read that clears an unreported flag, becomes visible only when the higher sources are gone. Masked and non-enhanced sources are therefore re-enabled after a read, which shows whether their flags survived. A wrong FIFO-mode or reset state appears immediately on bits 7:6 or bit 0.

// File: rtl/uart_irq_pkg.sv
// Package: shared source indices and identification codes for the
// interrupt identification unit. Assumes index order equals priority order.
package uart_irq_pkg;

    localparam int NUM_SRC   = 7;  // resolved sources, index 0 is highest
    localparam int CODE_W    = 6;  // width of the identification code field
    localparam int NUM_FLAGS = 5;  // sources held in latched flags
    localparam int NUM_EN    = 6;  // per-source enable bits

    typedef enum int {
        S_LINE  = 0,
        S_RXTO  = 1,
        S_RXRDY = 2,
        S_THR   = 3,
        S_MODEM = 4,
        S_XOFF  = 5,
        S_FLOW  = 6
    } src_e;

    // latched flag slots
    localparam int F_LINE  = 0;
    localparam int F_THR   = 1;
    localparam int F_MODEM = 2;
    localparam int F_XOFF  = 3;
    localparam int F_FLOW  = 4;

    localparam logic [CODE_W-1:0] IDLE_CODE = 6'h01;

    // Identification code for a resolved source index.
    function automatic logic [CODE_W-1:0] src_code(input int idx);
        logic [CODE_W-1:0] c;
        case (idx)
            S_LINE:  c = 6'h06;
            S_RXTO:  c = 6'h0C;
            S_RXRDY: c = 6'h04;
            S_THR:   c = 6'h02;
            S_MODEM: c = 6'h00;
            S_XOFF:  c = 6'h10;
            S_FLOW:  c = 6'h20;
            default: c = IDLE_CODE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/uart_irq_flags.sv
// Module: bank of set/clear interrupt flags.
// Each flag sets on its set strobe and clears on its clear strobe; a set
// in the same cycle as a clear wins. Assumes synchronous active-low reset.
module uart_irq_flags #(
    parameter int NUM = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] set_i,
    input  logic [NUM-1:0] clr_i,
    output logic [NUM-1:0] flag_o
);

    generate
        for (genvar i = 0; i < NUM; i++) begin : g_flag
            // Purpose: hold one pending condition until its clear strobe.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flag_o[i] <= 1'b0;
                else if (set_i[i])
                    flag_o[i] <= 1'b1;
                else if (clr_i[i])
                    flag_o[i] <= 1'b0;
            end

            // R10: a set strobe always leaves the flag high after the edge
            p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[i] |=> flag_o[i]);
            // clear without set drops the flag
            p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
        end
    endgenerate

endmodule

// File: rtl/uart_irq_prio.sv
// Module: fixed-priority resolver. Picks the lowest-indexed pending source,
// returns a one-hot grant and its identification code, or the idle code.
// Assumes the pending vector is already masked by enables.
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int NUM = NUM_SRC,
    parameter int CW  = CODE_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] pend_i,
    output logic [NUM-1:0] grant_o,
    output logic [CW-1:0]  code_o
);

    // Purpose: scan from lowest priority up so the highest pending wins.
    always_comb begin
        grant_o = '0;
        code_o  = IDLE_CODE;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                grant_o = '0;
                grant_o[i] = 1'b1;
                code_o  = src_code(i);
            end
        end
    end

    // R2: at most one source is reported
    p_onehot_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));
    // R3: nothing pending gives the idle code
    p_idle_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == '0) |-> (code_o == IDLE_CODE));
    // R3: any pending source clears bit 0
    p_pending_bit0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i != '0) |-> !code_o[0]);

endmodule

// File: rtl/uart_irq_ident.sv
// Module: interrupt identification unit for one UART channel.
// Latches event pulses, masks by per-source enables and the enhanced-mode
// enable, resolves priority and forms the status byte and interrupt line.
// Assumes CPU access strobes are single-cycle and synchronous to clk.
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fifo_en,
    input  logic                enh_en,
    input  logic [NUM_EN-1:0]   src_en,
    input  logic                ev_line_err,
    input  logic                rx_ready,
    input  logic                rx_timeout,
    input  logic                ev_thr_empty,
    input  logic                ev_modem,
    input  logic                ev_xoff,
    input  logic                ev_xon,
    input  logic                ev_flow_chg,
    input  logic                rd_status,
    input  logic                rd_line,
    input  logic                rd_modem,
    input  logic                wr_thr,
    output logic [7:0]          status,
    output logic                irq
);

    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flag_q;
    logic [NUM_SRC-1:0]   pend;
    logic [NUM_SRC-1:0]   grant;
    logic [CODE_W-1:0]    code;
    logic                 fifo_q;

    // Purpose: route event pulses to their flag set strobes.
    always_comb begin
        flag_set          = '0;
        flag_set[F_LINE]  = ev_line_err;
        flag_set[F_THR]   = ev_thr_empty;
        flag_set[F_MODEM] = ev_modem;
        flag_set[F_XOFF]  = ev_xoff;
        flag_set[F_FLOW]  = ev_flow_chg;
    end

    // Purpose: derive clear strobes from CPU accesses and the reported source.
    always_comb begin
        flag_clr          = '0;
        flag_clr[F_LINE]  = rd_line;
        flag_clr[F_THR]   = wr_thr | (rd_status & grant[S_THR]);
        flag_clr[F_MODEM] = rd_modem;
        flag_clr[F_XOFF]  = ev_xon;
        flag_clr[F_FLOW]  = rd_status & grant[S_FLOW];
    end

    uart_irq_flags #(.NUM(NUM_FLAGS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .clr_i  (flag_clr),
        .flag_o (flag_q)
    );

    // Purpose: mask raw conditions by enables ahead of priority resolution.
    always_comb begin
        pend          = '0;
        pend[S_LINE]  = flag_q[F_LINE]  & src_en[0];
        pend[S_RXTO]  = rx_timeout      & src_en[1];
        pend[S_RXRDY] = rx_ready        & src_en[1];
        pend[S_THR]   = flag_q[F_THR]   & src_en[2];
        pend[S_MODEM] = flag_q[F_MODEM] & src_en[3];
        pend[S_XOFF]  = flag_q[F_XOFF]  & src_en[4] & enh_en;
        pend[S_FLOW]  = flag_q[F_FLOW]  & src_en[5] & enh_en;
    end

    uart_irq_prio #(.NUM(NUM_SRC), .CW(CODE_W)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_i  (pend),
        .grant_o (grant),
        .code_o  (code)
    );

    // Purpose: register the FIFO-mode indication shown on bits 7:6.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fifo_q <= 1'b0;
        else
            fifo_q <= fifo_en;
    end

    // Purpose: assemble the status byte and the interrupt line.
    always_comb begin
        status = {fifo_q, fifo_q, code};
        irq    = ~code[0];
    end

    // R6: Xoff flag persists unless an Xon pulse arrives
    p_xoff_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[F_XOFF] && !ev_xon) |=> flag_q[F_XOFF]);
    // R8: status read while transmit empty is reported removes it
    p_thr_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && status[5:0] == 6'h02 && !ev_thr_empty) |=> !flag_q[F_THR]);
    // R5: enhanced levels hidden when enhanced mode is off
    p_enh_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !enh_en |-> (status[5:4] == 2'b00));
    // R4: FIFO-mode bits follow the enable one clock later
    p_fifo_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en |=> (status[7:6] == 2'b11));
    // R7: line flag is not disturbed by a status read alone
    p_line_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[F_LINE] && !rd_line) |=> flag_q[F_LINE]);

endmodule

// File: tb/uart_irq_ident_bench.sv
`timescale 1ns/1ps
module uart_irq_ident_bench;

    typedef struct packed {
        logic       rst_n;
        logic       fifo_en;
        logic       enh_en;
        logic [5:0] src_en;
        logic       rx_ready;
        logic       rx_timeout;
    } lvl_t;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    // pulse vector bit positions
    localparam int P_LINE = 0, P_THR = 1, P_MODEM = 2, P_XOFF = 3, P_XON = 4,
                   P_FLOW = 5, P_RDS = 6, P_RDL = 7, P_RDM = 8, P_WTHR = 9;

    logic        clk = 1'b0;
    lvl_t        lv;
    lvl_t        drv;
    logic [9:0]  pul;
    logic [7:0]  status;
    logic        irq;
    item_t       sb[$];
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    uart_irq_ident u_uart_irq_ident (
        .clk          (clk),
        .rst_n        (drv.rst_n),
        .fifo_en      (drv.fifo_en),
        .enh_en       (drv.enh_en),
        .src_en       (drv.src_en),
        .ev_line_err  (pul[P_LINE]),
        .rx_ready     (drv.rx_ready),
        .rx_timeout   (drv.rx_timeout),
        .ev_thr_empty (pul[P_THR]),
        .ev_modem     (pul[P_MODEM]),
        .ev_xoff      (pul[P_XOFF]),
        .ev_xon       (pul[P_XON]),
        .ev_flow_chg  (pul[P_FLOW]),
        .rd_status    (pul[P_RDS]),
        .rd_line      (pul[P_RDL]),
        .rd_modem     (pul[P_RDM]),
        .wr_thr       (pul[P_WTHR]),
        .status       (status),
        .irq          (irq)
    );

    // Driver: apply one cycle of stimulus at the falling edge, queue expectation.
    task automatic tick(input logic [9:0] p, input logic [7:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        drv = lv;
        pul = p;
        it.exp = exp;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare outputs mid-cycle against the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            #1.5;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (status !== it.exp || irq !== ~it.exp[0]) begin
                    errors++;
                    $display("FAIL %s: status=%02h irq=%b expected status=%02h irq=%b",
                             it.tag, status, irq, it.exp, ~it.exp[0]);
                end
            end
        end
    end

    // Stimulus sequence.
    initial begin
        lv = '{rst_n: 1'b0, fifo_en: 1'b1, enh_en: 1'b0, src_en: 6'h3F,
               rx_ready: 1'b0, rx_timeout: 1'b0};
        drv = lv;
        pul = '0;
        tick('0, 8'h01, "R1 reset idle");
        tick('0, 8'h01, "R1 reset idle");
        lv.rst_n = 1'b1;
        tick('0, 8'h01, "R4 fifo bits not yet");
        tick('0, 8'hC1, "R4 fifo bits set");
        tick(10'(1 << P_THR), 8'hC1, "R10 pulse not yet visible");
        tick('0, 8'hC2, "R2 thr code");
        tick(10'(1 << P_MODEM), 8'hC2, "R2 thr over modem");
        tick(10'(1 << P_LINE), 8'hC2, "R2 thr over modem");
        tick('0, 8'hC6, "R2 line highest");
        tick(10'(1 << P_RDS), 8'hC6, "R11 status read");
        tick('0, 8'hC6, "R7 line kept after status read");
        tick(10'(1 << P_RDL), 8'hC6, "R11 line read byte");
        tick('0, 8'hC2, "R7 line cleared by line read");
        tick(10'(1 << P_RDS), 8'hC2, "R11 thr read byte");
        tick('0, 8'hC0, "R8 thr cleared, modem code");
        tick(10'(1 << P_RDM), 8'hC0, "R3 modem pending bit0 low");
        tick('0, 8'hC1, "R7 modem cleared");
        lv.rx_ready = 1'b1;
        tick('0, 8'hC4, "R2 rx ready same cycle");
        lv.rx_timeout = 1'b1;
        tick('0, 8'hCC, "R2 timeout over ready");
        lv.rx_ready = 1'b0;
        lv.rx_timeout = 1'b0;
        tick('0, 8'hC1, "R2 rx levels gone");
        tick(10'((1 << P_XOFF) | (1 << P_FLOW)), 8'hC1, "R5 enhanced off");
        tick('0, 8'hC1, "R5 enhanced sources hidden");
        lv.enh_en = 1'b1;
        tick('0, 8'hD0, "R5 xoff shown after enable");
        tick(10'(1 << P_RDS), 8'hD0, "R6 status read of xoff");
        tick('0, 8'hD0, "R6 xoff sticky");
        tick(10'(1 << P_XON), 8'hD0, "R6 xon pulse");
        tick('0, 8'hE0, "R8 flow change shown");
        tick(10'(1 << P_RDS), 8'hE0, "R8 flow read");
        tick('0, 8'hC1, "R8 flow cleared by read");
        lv.src_en = 6'b111011;
        tick(10'(1 << P_THR), 8'hC1, "R9 thr masked");
        tick('0, 8'hC1, "R9 thr masked");
        tick(10'(1 << P_RDS), 8'hC1, "R9 status read while masked");
        lv.src_en = 6'h3F;
        tick('0, 8'hC2, "R9 raw flag kept");
        tick(10'(1 << P_WTHR), 8'hC2, "R8 thr write");
        tick('0, 8'hC1, "R8 thr cleared by write");
        tick(10'((1 << P_THR) | (1 << P_WTHR)), 8'hC1, "R10 set and clear");
        tick('0, 8'hC2, "R10 set wins");
        tick(10'(1 << P_WTHR), 8'hC2, "R8 thr write");
        tick('0, 8'hC1, "R8 thr cleared");
        lv.fifo_en = 1'b0;
        tick('0, 8'hC1, "R4 fifo off not yet");
        tick('0, 8'h01, "R4 fifo bits clear");
        tick(10'(1 << P_LINE), 8'h01, "R3 idle");
        tick('0, 8'h06, "R3 line pending no fifo");
        lv.rst_n = 1'b0;
        tick('0, 8'h06, "R1 before reset edge");
        tick('0, 8'h01, "R1 reset clears flags");
        @(negedge clk);
        pul = '0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule